// File: doc/BRIEF.md
# Command Slot Tracking Register Bank

This block keeps per-slot state for up to sixteen outstanding storage commands of a host controller. For each slot it holds three bits: a queued bit that software sets to hand a command to the controller, an active bit that hardware sets when the command goes out to the device, and a completed bit that hardware sets when the command finishes. Software sees the three bit sets as three 32-bit registers on a simple single-cycle read/write bus. The completed register is acknowledged by writing ones.

Hardware reports four kinds of event, each for one cycle. An issue or a completion carries a slot index. A device error report also carries a slot index. An error-clear pulse ends an error episode. While an error episode lasts, the active bits of commands already sent are held. When the error is cleared, every queued and active bit is flushed in one cycle. A level interrupt stays high while any completion waits for acknowledgement.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After synchronous active-high reset, the queued, active and completed registers read zero, no error episode is open and the interrupt is low.
- R2: The queued register is at offset 0x0, the active register at 0x4 and the completed register at 0x8. Slot n maps to data bit n (bits 15..0). Bits 31..16 always read zero, and a read of any other offset returns zero.
- R3: The queued register is read/write, and a write replaces bits 15..0. A write to the active register has no effect.
- R4: An issue event for slot n whose queued bit is 1 sets active bit n on the next clock edge.
- R5: A completion event for slot n whose queued bit is 1, outside an error episode, sets completed bit n on the next edge and clears queued bit n and active bit n on that same edge.
- R6: Issue and completion events for a slot whose queued bit is 0 change nothing.
- R7: A device error report for a slot whose active bit is 1 opens an error episode. A report for an inactive slot is ignored. During the episode completion events are ignored and no active bit falls, while issues are still accepted.
- R8: An error-clear pulse during an episode clears every queued and active bit, ends the episode and leaves the completed bits untouched. An error-clear pulse outside an episode has no effect.
- R9: Writing 1 to completed bit n clears it. Writing 0 leaves it unchanged.
- R10: When a completion sets completed bit n in the same cycle as software writes 1 to that bit, the bit ends at 1.
- R11: The interrupt output is high exactly while at least one completed bit is 1.
- R12: When a completion for slot n and a software write to the queued register occur in the same cycle, the written value applies to the other slots and queued bit n ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| issue_vld | input | 1 | Command sent to device |
| issue_slot | input | 4 | Slot of the issued command |
| done_vld | input | 1 | Command finished |
| done_slot | input | 4 | Slot of the finished command |
| err_vld | input | 1 | Device error report |
| err_slot | input | 4 | Slot named by the error report |
| err_clr | input | 1 | Software has cleared the device error |
| irq | output | 1 | Completion pending, level |

## Verification
The bench targets the same-cycle collisions. In one, a completion and a write-one-to-clear hit the same completed bit; a design with the priority reversed loses the completion and drops the interrupt. In another, a completion races a software write to the queued register; a design that lets software win leaves a finished slot marked as queued. The bench walks through a full error episode: an error report for an idle slot, a completion that must be held back, an issue that must still land, and the flush, which must keep the completed bits. A design that releases active bits early or clears acknowledgements on flush is caught by its register reads. Events on unqueued slots, writes to the read-only active register, zero writes to the completed register and reads of reserved bits and unmapped offsets are each read back to confirm that nothing moved.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int OFS_QUEUE  = 'h0;
    localparam int OFS_ACTIVE = 'h4;
    localparam int OFS_DONE   = 'h8;
endpackage

// File: rtl/cst_bus_decode.sv
module cst_bus_decode
    import cst_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SLOTS-1:0]  queue_q,
    input  logic [SLOTS-1:0]  active_q,
    input  logic [SLOTS-1:0]  done_q,
    output logic              queue_we,
    output logic [SLOTS-1:0]  queue_wval,
    output logic [SLOTS-1:0]  done_w1c,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_QUEUE  = ADDR_W'(OFS_QUEUE);
    localparam logic [ADDR_W-1:0] A_ACTIVE = ADDR_W'(OFS_ACTIVE);
    localparam logic [ADDR_W-1:0] A_DONE   = ADDR_W'(OFS_DONE);

    logic unused_rsvd_wdata;
    assign unused_rsvd_wdata = ^bus_wdata[DATA_W-1:SLOTS];

    always_comb begin
        queue_we   = bus_wr && (bus_addr == A_QUEUE);
        queue_wval = bus_wdata[SLOTS-1:0];
        done_w1c   = (bus_wr && (bus_addr == A_DONE)) ? bus_wdata[SLOTS-1:0] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_QUEUE:  bus_rdata[SLOTS-1:0] = queue_q;
            A_ACTIVE: bus_rdata[SLOTS-1:0] = active_q;
            A_DONE:   bus_rdata[SLOTS-1:0] = done_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cst_err_ctl.sv
module cst_err_ctl (
    input  logic err_q,
    input  logic err_hit,
    input  logic err_clr,
    output logic err_d,
    output logic flush
);
    always_comb begin
        flush = err_q && err_clr;
        if (flush)
            err_d = 1'b0;
        else if (err_hit)
            err_d = 1'b1;
        else
            err_d = err_q;
    end
endmodule

// File: rtl/cst_slot_cell.sv
module cst_slot_cell (
    input  logic queue_q,
    input  logic active_q,
    input  logic done_q,
    input  logic iss_hit,
    input  logic done_hit,
    input  logic err_mode,
    input  logic flush,
    input  logic queue_we,
    input  logic queue_wval,
    input  logic done_w1c,
    output logic queue_d,
    output logic active_d,
    output logic done_d
);
    logic iss_ok;
    logic done_ok;

    always_comb begin
        iss_ok  = iss_hit && queue_q;
        done_ok = done_hit && queue_q && !err_mode;

        if (flush || done_ok)
            queue_d = 1'b0;
        else if (queue_we)
            queue_d = queue_wval;
        else
            queue_d = queue_q;

        if (flush || done_ok)
            active_d = 1'b0;
        else if (iss_ok)
            active_d = 1'b1;
        else
            active_d = active_q;

        if (done_ok)
            done_d = 1'b1;
        else if (done_w1c)
            done_d = 1'b0;
        else
            done_d = done_q;
    end
endmodule

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker #(
    parameter int SLOTS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     issue_vld,
    input  logic [$clog2(SLOTS)-1:0] issue_slot,
    input  logic                     done_vld,
    input  logic [$clog2(SLOTS)-1:0] done_slot,
    input  logic                     err_vld,
    input  logic [$clog2(SLOTS)-1:0] err_slot,
    input  logic                     err_clr,
    output logic                     irq
);
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0] queue;
        logic [SLOTS-1:0] active;
        logic [SLOTS-1:0] done;
        logic             err;
    } trk_t;

    trk_t st_q, st_d;

    logic [SLOTS-1:0] queue_q, active_q, done_q;
    logic             err_q;
    logic [SLOTS-1:0] queue_n, active_n, done_n;
    logic [SLOTS-1:0] queue_wval, done_w1c;
    logic             queue_we, err_n, flush;

    assign queue_q  = st_q.queue;
    assign active_q = st_q.active;
    assign done_q   = st_q.done;
    assign err_q    = st_q.err;

    cst_bus_decode #(
        .SLOTS (SLOTS),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .queue_q   (queue_q),
        .active_q  (active_q),
        .done_q    (done_q),
        .queue_we  (queue_we),
        .queue_wval(queue_wval),
        .done_w1c  (done_w1c),
        .bus_rdata (bus_rdata)
    );

    cst_err_ctl u_err (
        .err_q  (err_q),
        .err_hit(err_vld && active_q[err_slot]),
        .err_clr(err_clr),
        .err_d  (err_n),
        .flush  (flush)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        cst_slot_cell u_cell (
            .queue_q   (queue_q[i]),
            .active_q  (active_q[i]),
            .done_q    (done_q[i]),
            .iss_hit   (issue_vld && (issue_slot == SLOT_W'(i))),
            .done_hit  (done_vld && (done_slot == SLOT_W'(i))),
            .err_mode  (err_q),
            .flush     (flush),
            .queue_we  (queue_we),
            .queue_wval(queue_wval[i]),
            .done_w1c  (done_w1c[i]),
            .queue_d   (queue_n[i]),
            .active_d  (active_n[i]),
            .done_d    (done_n[i])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.queue  = queue_n;
        st_d.active = active_n;
        st_d.done   = done_n;
        st_d.err    = err_n;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq = |done_q;
endmodule

// File: rtl/cst_checker.sv
module cst_checker
    import cst_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic [SLOTS-1:0]         bus_wdata_lo,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic                     issue_vld,
    input logic                     done_vld,
    input logic [$clog2(SLOTS)-1:0] done_slot,
    input logic                     err_clr,
    input logic [SLOTS-1:0]         queue_q,
    input logic [SLOTS-1:0]         active_q,
    input logic [SLOTS-1:0]         done_q,
    input logic                     err_q,
    input logic                     irq
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:SLOTS] == '0);

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_W'(OFS_QUEUE) && bus_addr != ADDR_W'(OFS_ACTIVE) &&
         bus_addr != ADDR_W'(OFS_DONE)) |-> bus_rdata == '0);

    // R3
    active_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_ACTIVE) && !issue_vld && !done_vld && !err_clr)
        |=> $stable(active_q));

    // R5
    done_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (done_vld && queue_q[done_slot] && !err_q)
        |=> (done_q[$past(done_slot)] && !active_q[$past(done_slot)] &&
             !queue_q[$past(done_slot)]));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> ((active_q & $past(active_q)) == $past(active_q)));

    // R8
    err_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && err_clr) |=> (queue_q == '0 && active_q == '0 && !err_q));

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_DONE) && !done_vld)
        |=> done_q == ($past(done_q) & ~$past(bus_wdata_lo)));

    // R11
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (done_vld && queue_q[done_slot] && !err_q) |=> irq);
endmodule

bind cmd_slot_tracker cst_checker #(
    .SLOTS (SLOTS),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata_lo(bus_wdata[SLOTS-1:0]),
    .bus_rdata   (bus_rdata),
    .issue_vld   (issue_vld),
    .done_vld    (done_vld),
    .done_slot   (done_slot),
    .err_clr     (err_clr),
    .queue_q     (queue_q),
    .active_q    (active_q),
    .done_q      (done_q),
    .err_q       (err_q),
    .irq         (irq)
);

// File: tb/cmd_slot_tracker_bench.sv
`timescale 1ns/1ps
module cmd_slot_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        issue_vld = 1'b0, done_vld = 1'b0, err_vld = 1'b0, err_clr = 1'b0;
    logic [3:0]  issue_slot = '0, done_slot = '0, err_slot = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cmd_slot_tracker u_cmd_slot_tracker (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .issue_vld(issue_vld), .issue_slot(issue_slot),
        .done_vld(done_vld), .done_slot(done_slot),
        .err_vld(err_vld), .err_slot(err_slot), .err_clr(err_clr),
        .irq(irq)
    );

    // entry: {req[3:0], kind[2:0], addr[3:0], slot[3:0], data[31:0]}
    // kinds: 0 write, 1 issue, 2 done, 3 error, 4 clear, 5 read-check, 6 irq-check
    localparam int NV = 23;
    localparam logic [46:0] VEC [NV] = '{
        {4'd3,  3'd0, 4'h0, 4'd0,  32'h0000_00FF},  // R3 queue slots 0..7
        {4'd3,  3'd5, 4'h0, 4'd0,  32'h0000_00FF},
        {4'd4,  3'd1, 4'h0, 4'd3,  32'h0},          // R4 issue 3
        {4'd4,  3'd1, 4'h0, 4'd5,  32'h0},          // R4 issue 5
        {4'd6,  3'd1, 4'h0, 4'd12, 32'h0},          // R6 issue on unqueued 12
        {4'd4,  3'd5, 4'h4, 4'd0,  32'h0000_0028},
        {4'd5,  3'd2, 4'h0, 4'd3,  32'h0},          // R5 complete 3
        {4'd5,  3'd5, 4'h8, 4'd0,  32'h0000_0008},
        {4'd5,  3'd5, 4'h4, 4'd0,  32'h0000_0020},
        {4'd5,  3'd5, 4'h0, 4'd0,  32'h0000_00F7},
        {4'd11, 3'd6, 4'h0, 4'd0,  32'h1},          // R11 irq high
        {4'd6,  3'd2, 4'h0, 4'd9,  32'h0},          // R6 complete on unqueued 9
        {4'd6,  3'd5, 4'h8, 4'd0,  32'h0000_0008},
        {4'd9,  3'd0, 4'h8, 4'd0,  32'h0},          // R9 zero write
        {4'd9,  3'd5, 4'h8, 4'd0,  32'h0000_0008},
        {4'd9,  3'd0, 4'h8, 4'd0,  32'h0000_0008},  // R9 ack
        {4'd9,  3'd5, 4'h8, 4'd0,  32'h0},
        {4'd11, 3'd6, 4'h0, 4'd0,  32'h0},          // R11 irq low
        {4'd3,  3'd0, 4'h4, 4'd0,  32'h0000_FFFF},  // R3 active is read-only
        {4'd3,  3'd5, 4'h4, 4'd0,  32'h0000_0020},
        {4'd2,  3'd0, 4'h0, 4'd0,  32'hFFFF_FFFF},
        {4'd2,  3'd5, 4'h0, 4'd0,  32'h0000_FFFF},  // R2 reserved bits
        {4'd2,  3'd5, 4'hC, 4'd0,  32'h0}           // R2 unmapped offset
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        bus_wr = 1'b0; issue_vld = 1'b0; done_vld = 1'b0; err_vld = 1'b0; err_clr = 1'b0;
    endtask

    task automatic rd(input int req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd(1, 4'h0, 32'h0);
        rd(1, 4'h4, 32'h0);
        rd(1, 4'h8, 32'h0);
        check(1, {31'd0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  req, ad, sl;
            logic [2:0]  kd;
            logic [31:0] dt;
            {req, kd, ad, sl, dt} = VEC[i];
            case (kd)
                3'd0: wr(ad, dt);
                3'd1: begin issue_slot = sl; issue_vld = 1'b1; tick(); end
                3'd2: begin done_slot = sl; done_vld = 1'b1; tick(); end
                3'd3: begin err_slot = sl; err_vld = 1'b1; tick(); end
                3'd4: begin err_clr = 1'b1; tick(); end
                3'd5: rd(int'(req), ad, dt);
                default: check(int'(req), {31'd0, irq}, dt);
            endcase
        end

        // R10 completion and ack on same bit, same cycle
        done_slot = 4'd5; done_vld = 1'b1;
        bus_addr = 4'h8; bus_wdata = 32'h20; bus_wr = 1'b1;
        tick();
        rd(10, 4'h8, 32'h0000_0020);
        rd(5,  4'h4, 32'h0);
        rd(5,  4'h0, 32'h0000_FFDF);
        wr(4'h8, 32'h20);

        // R12 completion racing a queue write
        done_slot = 4'd0; done_vld = 1'b1;
        bus_addr = 4'h0; bus_wdata = 32'h00FF; bus_wr = 1'b1;
        tick();
        rd(12, 4'h0, 32'h0000_00FE);
        rd(12, 4'h8, 32'h0000_0001);
        wr(4'h8, 32'h1);

        // R7 error episode
        issue_slot = 4'd1; issue_vld = 1'b1; tick();
        issue_slot = 4'd2; issue_vld = 1'b1; tick();
        done_slot = 4'd3; done_vld = 1'b1; tick();
        err_slot = 4'd9; err_vld = 1'b1; tick();       // inactive slot: ignored
        done_slot = 4'd1; done_vld = 1'b1; tick();
        rd(7, 4'h8, 32'h0000_000A);
        rd(7, 4'h4, 32'h0000_0004);
        err_slot = 4'd2; err_vld = 1'b1; tick();       // opens episode
        done_slot = 4'd2; done_vld = 1'b1; tick();     // held back
        issue_slot = 4'd4; issue_vld = 1'b1; tick();   // still accepted
        rd(7, 4'h4, 32'h0000_0014);
        rd(7, 4'h8, 32'h0000_000A);
        rd(7, 4'h0, 32'h0000_00F4);

        // R8 flush keeps completed bits
        err_clr = 1'b1; tick();
        rd(8, 4'h0, 32'h0);
        rd(8, 4'h4, 32'h0);
        rd(8, 4'h8, 32'h0000_000A);
        check(11, {31'd0, irq}, 32'h1);
        wr(4'h0, 32'h3);
        err_clr = 1'b1; tick();                        // outside episode: no effect
        rd(8, 4'h0, 32'h0000_0003);
        done_slot = 4'd0; done_vld = 1'b1; tick();
        rd(8, 4'h8, 32'h0000_000B);
        rd(8, 4'h0, 32'h0000_0002);

        // R1 reset from a busy state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd(1, 4'h0, 32'h0);
        rd(1, 4'h8, 32'h0);
        check(1, {31'd0, irq}, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule